// File: doc/BRIEF.md
# Burst-of-Four Double-Rate SRAM Master

This block sits between a simple host request port and a synchronous SRAM that moves every access as a burst of four data words, two per clock cycle. The host offers one request at a time: an address, a direction bit and, for writes, four data words packed into one vector. Once the request is taken, the block drives the memory's load strobe, direction select and address for one memory clock cycle. It then places the four write words on the data bus starting one full cycle later, or collects four read words starting one and a half cycles later. For reads the host gets all four words at once, together with a single-beat valid pulse.

All logic runs on one rising edge of a clock at twice the memory clock rate. Each edge of that clock marks one half-cycle "beat". An output `mem_kphase` tells which half of the memory cycle the current beat is: 0 is the first half, whose start is the memory's load edge, and 1 is the second half. The write path and the read path have separate delay lines because write data lags the command by two beats and read data by three. The scheduler holds off the host so that bursts never collide on the shared data bus. When a write follows a read, it also leaves one idle beat on the bus as a turnaround.

Top module: `sram_b4_master`

## Requirements
- R1: While `rst_n` is low, `mem_load_n` and `mem_rw_n` are 1, `mem_dq_oe`, `rsp_valid`, `req_ready` and `mem_kphase` are 0, and the memory therefore sees no command.
- R2: After reset, `mem_kphase` toggles on every beat. `req_ready` is never 1 in a beat where `mem_kphase` is 0, so a request is accepted only on the clock edge that ends the second half of a memory cycle.
- R3: A request accepted on an edge drives `mem_load_n` low for exactly the next two beats (the first with `mem_kphase` 0). In those beats `mem_addr` equals the accepted address and `mem_rw_n` is 1 for a read and 0 for a write. In the beat after that, `mem_load_n` is high again unless a new command starts.
- R4: For a write whose command occupies beats 0 and 1, `mem_dq_oe` is 1 in beats 2, 3, 4 and 5. `mem_dq_out` carries word 0, 1, 2 and 3 of `req_wdata` in those beats, where word i is bits [i*DW +: DW].
- R5: For a read whose command occupies beats 0 and 1, the values on `mem_dq_in` during beats 3, 4, 5 and 6 are captured as words 0 to 3. In beat 7, `rsp_valid` is 1 for one beat and `rsp_rdata` holds word i in bits [i*DW +: DW].
- R6: Two successive command starts (falling edges of `mem_load_n`) are at least 4 beats apart. With a request held valid, the gap is exactly 4 beats for write-write, read-read and write-then-read.
- R7: A write that follows a read starts exactly 6 beats after the read's command when the request is held valid, leaving one undriven beat between the last read word and the first write word.
- R8: Outside the four write-data beats of a write, `mem_dq_oe` is 0. This includes idle (no-operation) cycles, in which `mem_load_n` and `mem_rw_n` stay 1.
- R9: `rsp_valid` pulses exactly once per accepted read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; each rising edge ends one beat |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request is taken on this edge if valid |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | AW | Burst start address |
| req_wdata | input | 4*DW | Write words, word i at [i*DW +: DW] |
| rsp_valid | output | 1 | One-beat pulse: read burst complete |
| rsp_rdata | output | 4*DW | Read words, word i at [i*DW +: DW] |
| mem_kphase | output | 1 | 0 in the first half of a memory cycle, 1 in the second |
| mem_load_n | output | 1 | Active-low load strobe to the memory |
| mem_rw_n | output | 1 | 1 = read, 0 = write, valid while load is low |
| mem_addr | output | AW | Address to the memory |
| mem_dq_out | output | DW | Write word driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DW | Data bus value seen from the memory |

## Verification
Single isolated writes and reads are issued at the lowest and highest addresses, with all-zero, all-one, alternating and per-word-distinct data. Distinct words reveal a wrong word order or an off-by-one-beat alignment on either path, and the extreme patterns reveal stuck or swapped bits. Back-to-back pairs are then issued with the request held valid in all four direction orders. The measured gap between command starts tells the shared 4-beat minimum apart from the 6-beat write-after-read turnaround. Counting response pulses against reads issued separates "one pulse per read" from spurious pulses on writes.

// File: rtl/sb4_pkg.sv
// Shared constants for the burst-of-four double-rate SRAM master.
// Assumes a fixed burst length of four words, two per memory cycle.
package sb4_pkg;
    localparam int BEATS      = 4;             // words per burst
    localparam int CMD_CYC    = BEATS / 2;     // memory cycles a burst holds the bus
    localparam int MIN_GAP    = CMD_CYC - 1;   // skipped issue slots between commands
    localparam int TURN_GAP   = CMD_CYC;       // skipped slots for write after read
    localparam int WR_LEAD    = 2;             // beats from command to first write word
    localparam int RD_LEAD    = 3;             // beats from command to first read word
    localparam int RD_PIPE    = RD_LEAD + BEATS;

    typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} dir_e;
endpackage

// File: rtl/sb4_sched.sv
// Issue scheduler: generates the half-cycle phase and decides when a host
// request may be accepted. Assumes requests are taken only at the end of a
// memory cycle and that a burst occupies CMD_CYC cycles of data bus time.
// req_ready looks at req_read so that a write after a read waits one more slot.
module sb4_sched
    import sb4_pkg::*;
(
    input  logic clk2x,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_read,
    output logic req_ready,
    output logic accept,
    output logic kphase
);
    localparam int SW = $clog2(TURN_GAP + 2);
    localparam logic [SW-1:0] SAT = SW'(TURN_GAP + 1);

    logic          ph;
    logic [SW-1:0] since;
    dir_e          last_dir;
    logic [SW-1:0] need;

    // Required idle slots depend on the direction change.
    always_comb begin
        if (last_dir == DIR_READ && !req_read)
            need = SW'(TURN_GAP);
        else
            need = SW'(MIN_GAP);
    end

    assign req_ready = ph && (since >= need);
    assign accept    = req_valid && req_ready;
    assign kphase    = ph;

    // Phase toggle, slot counter and last direction.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            ph       <= 1'b0;
            since    <= SAT;
            last_dir <= DIR_WRITE;
        end else begin
            ph <= ~ph;
            if (accept) begin
                since    <= '0;
                last_dir <= req_read ? DIR_READ : DIR_WRITE;
            end else if (ph && since != SAT) begin
                since <= since + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb4_cmd.sv
// Command driver: holds the load strobe, direction and address on the memory
// pins for the two beats of the memory cycle that follows an accepted request.
// Assumes accept only arrives at the end of a second-half beat.
module sb4_cmd #(
    parameter int AW = 18
) (
    input  logic          clk2x,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          acc_read,
    input  logic [AW-1:0] acc_addr,
    input  logic          kphase,
    output logic          load_n,
    output logic          rw_n,
    output logic [AW-1:0] addr
);
    // Launch on accept, release at the end of the command cycle.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            load_n <= 1'b1;
            rw_n   <= 1'b1;
            addr   <= '0;
        end else if (accept) begin
            load_n <= 1'b0;
            rw_n   <= acc_read;
            addr   <= acc_addr;
        end else if (kphase) begin
            load_n <= 1'b1;
            rw_n   <= 1'b1;
        end
    end
endmodule

// File: rtl/sb4_wr_ser.sv
// Write serializer: keeps the four write words of the newest write and, WR_LEAD
// beats after the command starts, drives them one per beat with the bus enable
// high. Assumes writes are at least BEATS beats apart, so the copy taken at
// launch frees the holding buffer for the next write.
module sb4_wr_ser
    import sb4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                clk2x,
    input  logic                rst_n,
    input  logic                wr_acc,
    input  logic [BEATS*DW-1:0] wr_data,
    output logic [DW-1:0]       dq_out,
    output logic                dq_oe
);
    localparam int IW = $clog2(BEATS);

    logic [DW-1:0]      hold [BEATS];
    logic [DW-1:0]      shr  [BEATS];
    logic [WR_LEAD-1:0] lead;
    logic [IW-1:0]      nxt;
    logic               busy;
    logic               launch;

    assign launch = lead[WR_LEAD-1];

    // Delay line marking when the first write word is due.
    always_ff @(posedge clk2x) begin
        if (!rst_n) lead <= '0;
        else        lead <= {lead[WR_LEAD-2:0], wr_acc};
    end

    genvar gi;
    generate
        for (gi = 0; gi < BEATS; gi++) begin : g_word
            // Capture word gi of the accepted write.
            always_ff @(posedge clk2x) begin
                if (!rst_n)      hold[gi] <= '0;
                else if (wr_acc) hold[gi] <= wr_data[gi*DW +: DW];
            end
            // Working copy taken at launch.
            always_ff @(posedge clk2x) begin
                if (!rst_n)      shr[gi] <= '0;
                else if (launch) shr[gi] <= hold[gi];
            end
        end
    endgenerate

    // Beat-by-beat output of the four words.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
            nxt    <= '0;
            busy   <= 1'b0;
        end else if (launch) begin
            dq_out <= hold[0];
            dq_oe  <= 1'b1;
            nxt    <= IW'(1);
            busy   <= 1'b1;
        end else if (busy) begin
            dq_out <= shr[nxt];
            dq_oe  <= 1'b1;
            nxt    <= nxt + 1'b1;
            busy   <= (nxt != IW'(BEATS - 1));
        end else begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end
    end
endmodule

// File: rtl/sb4_rd_deser.sv
// Read collector: samples the data bus at the end of beats RD_LEAD to
// RD_LEAD+3 after a read command starts and presents all four words with a
// one-beat valid. Assumes reads are at least BEATS beats apart; the collection
// registers and the output register are separate, so successive reads do not
// disturb a finished result.
module sb4_rd_deser
    import sb4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                clk2x,
    input  logic                rst_n,
    input  logic                rd_acc,
    input  logic [DW-1:0]       dq_in,
    output logic                rsp_valid,
    output logic [BEATS*DW-1:0] rsp_rdata
);
    logic [RD_PIPE-1:0] pipe;
    logic [DW-1:0]      col [BEATS-1];
    logic               last;

    assign last = pipe[RD_LEAD + BEATS - 1];

    // Delay line tracking the position of each outstanding read.
    always_ff @(posedge clk2x) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[RD_PIPE-2:0], rd_acc};
    end

    genvar gi;
    generate
        for (gi = 0; gi < BEATS - 1; gi++) begin : g_col
            // Sample word gi at the end of its beat.
            always_ff @(posedge clk2x) begin
                if (!rst_n)                 col[gi] <= '0;
                else if (pipe[RD_LEAD + gi]) col[gi] <= dq_in;
            end
        end
    endgenerate

    // Assemble the burst and pulse valid with the last word.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= last;
            if (last) begin
                for (int i = 0; i < BEATS - 1; i++)
                    rsp_rdata[i*DW +: DW] <= col[i];
                rsp_rdata[(BEATS-1)*DW +: DW] <= dq_in;
            end
        end
    end
endmodule

// File: rtl/sram_b4_master.sv
// Top of the burst-of-four double-rate SRAM master. Accepts host requests,
// drives the memory command for one memory cycle, and sends or collects four
// data words on half-cycle beats. Assumes clk2x runs at twice the memory clock
// and that the pad logic turns beats into the two memory clock phases.
module sram_b4_master
    import sb4_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic                clk2x,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_read,
    input  logic [AW-1:0]       req_addr,
    input  logic [BEATS*DW-1:0] req_wdata,
    output logic                rsp_valid,
    output logic [BEATS*DW-1:0] rsp_rdata,
    output logic                mem_kphase,
    output logic                mem_load_n,
    output logic                mem_rw_n,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DW-1:0]       mem_dq_in
);
    logic accept;
    logic acc_wr;
    logic acc_rd;

    assign acc_wr = accept && !req_read;
    assign acc_rd = accept && req_read;

    sb4_sched u_sched (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_ready (req_ready),
        .accept    (accept),
        .kphase    (mem_kphase)
    );

    sb4_cmd #(.AW(AW)) u_cmd (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .accept   (accept),
        .acc_read (req_read),
        .acc_addr (req_addr),
        .kphase   (mem_kphase),
        .load_n   (mem_load_n),
        .rw_n     (mem_rw_n),
        .addr     (mem_addr)
    );

    sb4_wr_ser #(.DW(DW)) u_wr (
        .clk2x   (clk2x),
        .rst_n   (rst_n),
        .wr_acc  (acc_wr),
        .wr_data (req_wdata),
        .dq_out  (mem_dq_out),
        .dq_oe   (mem_dq_oe)
    );

    sb4_rd_deser #(.DW(DW)) u_rd (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .rd_acc    (acc_rd),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/sb4_checker.sv
// Protocol checker for sram_b4_master, attached by bind. Watches the host
// handshake and memory pins and tracks command spacing with its own counter.
module sb4_checker #(
    parameter int AW = 18
) (
    input logic          clk2x,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_read,
    input logic [AW-1:0] req_addr,
    input logic          rsp_valid,
    input logic          mem_kphase,
    input logic          mem_load_n,
    input logic          mem_rw_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_dq_oe
);
    localparam int GAP_MIN  = 4;
    localparam int GAP_TURN = 6;

    logic       load_q;
    logic       last_rd;
    logic [3:0] gap;
    logic       start;

    assign start = !mem_load_n && load_q;

    // Beats since the previous command start and its direction.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            load_q  <= 1'b1;
            last_rd <= 1'b0;
            gap     <= 4'hF;
        end else begin
            load_q <= mem_load_n;
            if (start) begin
                gap     <= 4'd1;
                last_rd <= mem_rw_n;
            end else if (gap != 4'hF) begin
                gap <= gap + 4'd1;
            end
        end
    end

    a_r2_ready_in_second_half: assert property (@(posedge clk2x) disable iff (!rst_n)
        req_ready |-> mem_kphase);
    a_r2_phase_toggles: assert property (@(posedge clk2x) disable iff (!rst_n)
        mem_kphase |=> !mem_kphase);
    a_r3_cmd_follows_accept: assert property (@(posedge clk2x) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!mem_load_n && mem_addr == $past(req_addr)
                                       && mem_rw_n == $past(req_read)));
    a_r3_load_two_beats: assert property (@(posedge clk2x) disable iff (!rst_n)
        start |=> !mem_load_n ##1 mem_load_n);
    a_r4_write_data_lead: assert property (@(posedge clk2x) disable iff (!rst_n)
        (start && !mem_rw_n) |-> ##2 mem_dq_oe);
    a_r5_single_pulse: assert property (@(posedge clk2x) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r9_read_response: assert property (@(posedge clk2x) disable iff (!rst_n)
        (start && mem_rw_n) |-> ##7 rsp_valid);
    a_r8_no_drive_on_read: assert property (@(posedge clk2x) disable iff (!rst_n)
        (start && mem_rw_n) |-> ##3 !mem_dq_oe);
    a_r6_min_spacing: assert property (@(posedge clk2x) disable iff (!rst_n)
        start |-> gap >= 4'(GAP_MIN));
    a_r7_turnaround: assert property (@(posedge clk2x) disable iff (!rst_n)
        (start && !mem_rw_n && last_rd) |-> gap >= 4'(GAP_TURN));
endmodule

bind sram_b4_master sb4_checker #(.AW(AW)) u_chk (
    .clk2x      (clk2x),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_read   (req_read),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .mem_kphase (mem_kphase),
    .mem_load_n (mem_load_n),
    .mem_rw_n   (mem_rw_n),
    .mem_addr   (mem_addr),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_b4_master_tb.sv
module sram_b4_master_tb;
    localparam int CLK_P = 10;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int FW = 4 * DW;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
        logic [FW-1:0] data;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 18'h00000, 64'h4444_3333_2222_1111},
        '{1'b1, 18'h00000, 64'hDDDD_CCCC_BBBB_AAAA},
        '{1'b0, 18'h3FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b1, 18'h3FFFF, 64'h0000_0000_0000_0000},
        '{1'b0, 18'h15555, 64'h5555_AAAA_5555_AAAA},
        '{1'b1, 18'h2AAAA, 64'hA5A5_5A5A_0F0F_F0F0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_read = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [FW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [FW-1:0] rsp_rdata;
    logic          mem_kphase;
    logic          mem_load_n;
    logic          mem_rw_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_in = '0;

    int checks = 0;
    int fails = 0;
    int reads_issued = 0;
    int rsp_seen = 0;
    bit finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    sram_b4_master #(.AW(AW), .DW(DW)) u_dut (
        .clk2x(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_kphase(mem_kphase), .mem_load_n(mem_load_n), .mem_rw_n(mem_rw_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    always @(posedge clk) if (rst_n && rsp_valid) rsp_seen++;

    task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present a request and return at the negedge of command beat 0.
    task automatic issue(input logic rd, input logic [AW-1:0] a,
                         input logic [FW-1:0] d, input bit check_r2);
        @(negedge clk);
        req_valid = 1'b1;
        req_read  = rd;
        req_addr  = a;
        req_wdata = rd ? '0 : d;
        for (int g = 0; g < 16; g++) begin
            logic rdy;
            rdy = req_ready;
            if (check_r2 && !mem_kphase)
                chk(!rdy, "R2 ready in first half", FW'(rdy), '0);
            @(negedge clk);
            if (rdy) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic run_txn(input vec_t v);
        issue(v.rd, v.addr, v.data, 1'b1);
        // beat 0
        chk(!mem_load_n, "R3 load low beat0", FW'(mem_load_n), '0);
        chk(mem_addr == v.addr, "R3 address", FW'(mem_addr), FW'(v.addr));
        chk(mem_rw_n == v.rd, "R3 direction", FW'(mem_rw_n), FW'(v.rd));
        chk(!mem_kphase, "R2 command in first half", FW'(mem_kphase), '0);
        @(negedge clk); // beat 1
        chk(!mem_load_n, "R3 load low beat1", FW'(mem_load_n), '0);
        @(negedge clk); // beat 2
        chk(mem_load_n, "R3 load released", FW'(mem_load_n), FW'(1));
        if (!v.rd) begin
            for (int i = 0; i < 4; i++) begin
                chk(mem_dq_oe && mem_dq_out == v.data[i*DW +: DW], "R4 write word",
                    {mem_dq_oe, mem_dq_out}, {1'b1, v.data[i*DW +: DW]});
                @(negedge clk);
            end
            chk(!mem_dq_oe, "R8 bus released after write", FW'(mem_dq_oe), '0);
        end else begin
            chk(!mem_dq_oe, "R8 no drive during read", FW'(mem_dq_oe), '0);
            @(negedge clk); // beat 3
            for (int i = 0; i < 4; i++) begin
                mem_dq_in = v.data[i*DW +: DW];
                if (i == 3)
                    chk(!rsp_valid, "R5 valid not early", FW'(rsp_valid), '0);
                @(negedge clk);
            end
            mem_dq_in = '0;
            reads_issued++;
            chk(rsp_valid && rsp_rdata == v.data, "R5 read burst",
                rsp_rdata, v.data);
            @(negedge clk);
            chk(!rsp_valid, "R9 single pulse", FW'(rsp_valid), '0);
        end
        repeat (6) @(negedge clk);
    endtask

    // Hold the request valid across two commands and measure start spacing.
    task automatic measure(input logic r1, input logic r2, input int exp,
                           input string tag);
        int   gap;
        logic prev;
        repeat (6) @(negedge clk);
        issue(r1, 18'h00100, 64'h1, 1'b0);
        req_valid = 1'b1;
        req_read  = r2;
        req_addr  = 18'h00200;
        req_wdata = r2 ? '0 : 64'h2;
        prev = mem_load_n;
        gap  = 0;
        for (int g = 1; g <= 20; g++) begin
            @(negedge clk);
            if (prev && !mem_load_n) begin
                gap = g;
                break;
            end
            prev = mem_load_n;
        end
        req_valid = 1'b0;
        chk(gap == exp, tag, FW'(gap), FW'(exp));
        if (r1) reads_issued++;
        if (r2) reads_issued++;
        repeat (14) @(negedge clk);
    endtask

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_load_n && mem_rw_n, "R1 command idle in reset",
            FW'({mem_load_n, mem_rw_n}), FW'(2'b11));
        chk(!mem_dq_oe && !rsp_valid && !req_ready, "R1 outputs quiet in reset",
            FW'({mem_dq_oe, rsp_valid, req_ready}), '0);
        chk(!mem_kphase, "R1 phase in reset", FW'(mem_kphase), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_kphase, "R2 phase toggles", FW'(mem_kphase), FW'(1));
        @(negedge clk);
        chk(!mem_kphase, "R2 phase toggles back", FW'(mem_kphase), '0);

        foreach (VEC[k]) run_txn(VEC[k]);

        measure(1'b0, 1'b0, 4, "R6 write-write spacing");
        measure(1'b1, 1'b1, 4, "R6 read-read spacing");
        measure(1'b0, 1'b1, 4, "R6 write-read spacing");
        measure(1'b1, 1'b0, 6, "R7 write-after-read turnaround");

        // R8 idle cycles
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!mem_load_n || !mem_rw_n || mem_dq_oe) bad++;
        end
        chk(bad == 0, "R8 idle bus", FW'(bad), '0);
        chk(rsp_seen == reads_issued, "R9 responses per read",
            FW'(rsp_seen), FW'(reads_issued));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule